// File: doc/BRIEF.md
# I2C Staged Register Slave with Synchronized Commit

This block is a register file that a host programs over a two-wire I2C bus. The block answers only to a fixed device address. The first byte after a write address selects a sub-address pointer. That pointer then advances by one after every data byte, whether the byte is written or read. Bytes written to register sub-addresses are held in a staging copy. The rest of the chip sees only the active copy, which is brought out on a wide output port.

Staged values reach the active copy in two steps. First, the host writes any byte to the reserved store sub-address. This arms all three commit groups. Each register belongs to one group, chosen by a parameter: main vertical sync, secondary vertical sync, or output-cycle start. Each armed group then copies its staged bytes into the active copy on the next pulse of its own sync input, and disarms. This lets several related settings change together at a known frame boundary. Three read-only status sub-addresses show which groups are still waiting for their pulse.

The bus lines are oversampled in the system clock domain. The block has no clock stretching and drives SDA only as an open-drain pull-down enable.

Top module: `i2c_staged_regs`

## Requirements
- R1: The block acknowledges only the address bytes 0xBC (write) and 0xBD (read). After any other address byte it leaves SDA released for the ACK slot and for the rest of the transfer.
- R2: In a write transfer, the block acknowledges the sub-address byte and every data byte. The pointer is loaded from the sub-address byte and increments by one after each data byte.
- R3: In a read transfer (0xBC, sub-address, repeated START, 0xBD), the block shifts out bytes MSB first, starting at the pointer, and advances the pointer per byte. After the master NACKs a byte, the block releases SDA and stays released. A STOP always releases SDA.
- R4: The pointer wraps from 0xFF to 0x00, in both write and read transfers.
- R5: A write to a register sub-address (0 to NREG-1) changes only its staged byte. `regs_o` does not change until that register's group commits.
- R6: Writing any byte to sub-address 0xFF arms all three groups, so every status bit reads 1.
- R7: A high sync input of an armed group copies that group's staged bytes into `regs_o` one clock later, and clears that group's status bit. A sync pulse for a group that is not armed has no effect. Other groups are left alone.
- R8: Sub-addresses 0x80, 0x81 and 0x82 read as {7'b0, pending} for the main-vsync, secondary-vsync and output-start groups. Writes to them are ignored.
- R9: A store issued while a group is still armed keeps it armed. The later commit copies the staged bytes present at the pulse, including bytes written after the store.
- R10: Reads of a register sub-address return the active byte, not the staged one. Reads of unassigned sub-addresses return 0x00, and writes to them change nothing.
- R11: With the default map, registers 0 to 2 use group code 0 (main vsync), registers 3 and 4 use code 1 (secondary vsync), and registers 5 to 7 use code 2 (output start). Register i appears on `regs_o[8i+7:8i]`.
- R12: Transfers work at 100 kHz and at 400 kHz SCL rates with the 125 MHz system clock.
- R13: After reset, all active, staged and pending state is zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| vsync_main_i | input | 1 | Commit pulse for group 0 |
| vsync_sec_i | input | 1 | Commit pulse for group 1 |
| out_start_i | input | 1 | Commit pulse for group 2 |
| regs_o | output | NREG*8 | Active register bytes, register i at [8i+7:8i] |

## Verification
Active outputs change exactly one clock after a sync input is high with its group armed. The reference model applies its commit at that same rising edge, and `regs_o` is compared with the model at every falling edge. ACK and read-data bits appear on SDA a few clocks after the synchronized SCL falling edge, because of the two-flop stage, the edge register and the output register. The bench samples SDA only at the middle of the SCL high phase, which is at least a quarter SCL period after that edge. Staging and arming in the model are updated only after the bus byte finishes, and sync pulses are issued only while the bus is idle, so model and design never disagree in between.

// File: rtl/i2c_stg_pkg.sv
// Shared types and constants for the staged I2C register slave.
// Assumes at most 128 registers so register and status sub-addresses never overlap.
package i2c_stg_pkg;

    localparam int NGRP = 3;
    localparam logic [7:0] STORE_SUB = 8'hFF;
    localparam logic [7:0] STAT_BASE = 8'h80;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK
    } slv_state_e;

endpackage

// File: rtl/i2c_pin_sync.sv
// Brings SCL/SDA into the system clock domain and flags SCL edges, START and STOP.
// Assumes the system clock is many times faster than SCL; idle bus level is high.
module i2c_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_sr;
    logic [STAGES-1:0] sda_sr;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    // Synchronizer chains plus one history flop per line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[STAGES-2:0], scl_i};
            sda_sr <= {sda_sr[STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s = scl_sr[STAGES-1];
    assign sda_s = sda_sr[STAGES-1];

    // Edge and bus-condition decode from current and previous samples.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_slave_fsm.sv
// Byte-level I2C slave: address match, sub-address pointer, write strobes, read shifting.
// Assumes edges come from i2c_pin_sync; SDA is only ever changed after an SCL falling edge.
module i2c_slave_fsm
    import i2c_stg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h5E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic [7:0] ptr,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       sda_oe
);

    slv_state_e state;
    logic [2:0] bitcnt;
    logic [7:0] shreg;
    logic       byte_rdy;
    logic       rw;
    logic       mack;

    // Protocol sequencer: bus conditions first, then sampling on rise, driving on fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            byte_rdy <= 1'b0;
            rw       <= 1'b0;
            mack     <= 1'b0;
            ptr      <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            sda_oe   <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state    <= ST_ADDR;
                bitcnt   <= '0;
                byte_rdy <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                byte_rdy <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (scl_rise) begin
                case (state)
                    ST_ADDR, ST_SUB, ST_WDAT: begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) begin
                            byte_rdy <= 1'b1;
                        end
                    end
                    ST_RACK: mack <= ~sda_s;
                    default: ;
                endcase
            end else if (scl_fall) begin
                case (state)
                    ST_ADDR: begin
                        if (byte_rdy) begin
                            byte_rdy <= 1'b0;
                            if (shreg[7:1] == DEV_ADDR) begin
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_SUB: begin
                        if (byte_rdy) begin
                            byte_rdy <= 1'b0;
                            ptr      <= shreg;
                            sda_oe   <= 1'b1;
                            state    <= ST_SUB_ACK;
                        end
                    end
                    ST_WDAT: begin
                        if (byte_rdy) begin
                            byte_rdy <= 1'b0;
                            wr_en    <= 1'b1;
                            wr_addr  <= ptr;
                            wr_data  <= shreg;
                            ptr      <= ptr + 8'd1;
                            sda_oe   <= 1'b1;
                            state    <= ST_WDAT_ACK;
                        end
                    end
                    ST_ADDR_ACK: begin
                        bitcnt <= '0;
                        if (rw) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            ptr    <= ptr + 8'd1;
                            state  <= ST_RDAT;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_SUB;
                        end
                    end
                    ST_SUB_ACK, ST_WDAT_ACK: begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        state  <= ST_WDAT;
                    end
                    ST_RDAT: begin
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                        end
                    end
                    ST_RACK: begin
                        if (mack) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            ptr    <= ptr + 8'd1;
                            bitcnt <= '0;
                            state  <= ST_RDAT;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/stg_reg_bank.sv
// Staging and active register copies, per-group commit arming and read-back mux.
// Assumes GROUP_MAP holds a 2-bit group code per register (0, 1, 2; 3 treated as 2).
module stg_reg_bank
    import i2c_stg_pkg::*;
#(
    parameter int                  NREG      = 8,
    parameter logic [2*NREG-1:0]   GROUP_MAP = 16'hA940
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [NGRP-1:0]   sync_i,
    input  logic [7:0]        rd_addr,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] act_o,
    output logic [NGRP-1:0]   pend_o
);

    logic [7:0]      stage_q [NREG];
    logic [7:0]      act_q   [NREG];
    logic [NGRP-1:0] pend_q;
    logic [NREG-1:0] commit_en;
    logic            store;

    assign store  = wr_en && (wr_addr == STORE_SUB);
    assign pend_o = pend_q;

    // Per-register commit enable chosen by the register's group code.
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [1:0] GC = GROUP_MAP[2*i +: 2];
        if (GC == 2'd0) begin : g_main
            assign commit_en[i] = sync_i[0] & pend_q[0];
        end else if (GC == 2'd1) begin : g_sec
            assign commit_en[i] = sync_i[1] & pend_q[1];
        end else begin : g_out
            assign commit_en[i] = sync_i[2] & pend_q[2];
        end
        assign act_o[8*i +: 8] = act_q[i];
    end

    // Staging capture of bus writes to register sub-addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) stage_q[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_addr == 8'(i)) stage_q[i] <= wr_data;
            end
        end
    end

    // Transfer of staged bytes into the active copy on an armed group's pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) act_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (commit_en[i]) act_q[i] <= stage_q[i];
            end
        end
    end

    // Arming: store sets every group, a group's own pulse disarms it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (store) begin
            pend_q <= '1;
        end else begin
            pend_q <= pend_q & ~sync_i;
        end
    end

    // Read-back: active registers, status bytes, zero elsewhere.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == 8'(i)) rd_data = act_q[i];
        end
        for (int g = 0; g < NGRP; g++) begin
            if (rd_addr == STAT_BASE + 8'(g)) rd_data = {7'b0, pend_q[g]};
        end
    end

endmodule

// File: rtl/i2c_staged_regs.sv
// Top: I2C slave register file whose writes reach the outputs only through store-and-sync commits.
// Assumes synchronous single-cycle sync pulses in the clk domain and an open-drain SDA pad outside.
module i2c_staged_regs
    import i2c_stg_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR    = 7'h5E,
    parameter int                NREG        = 8,
    parameter logic [2*NREG-1:0] GROUP_MAP   = 16'hA940,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              vsync_main_i,
    input  logic              vsync_sec_i,
    input  logic              out_start_i,
    output logic [NREG*8-1:0] regs_o
);

    logic            sda_s;
    logic            scl_rise;
    logic            scl_fall;
    logic            start_det;
    logic            stop_det;
    logic [7:0]      ptr;
    logic [7:0]      rd_data;
    logic            wr_en;
    logic [7:0]      wr_addr;
    logic [7:0]      wr_data;
    logic [NGRP-1:0] sync_vec;
    logic [NGRP-1:0] pend_vec;

    assign sync_vec = {out_start_i, vsync_sec_i, vsync_main_i};

    i2c_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_slave_fsm #(
        .DEV_ADDR (DEV_ADDR)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe_o)
    );

    stg_reg_bank #(
        .NREG      (NREG),
        .GROUP_MAP (GROUP_MAP)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sync_i  (sync_vec),
        .rd_addr (ptr),
        .rd_data (rd_data),
        .act_o   (regs_o),
        .pend_o  (pend_vec)
    );

endmodule

// File: rtl/i2c_staged_regs_chk.sv
// Property checker for i2c_staged_regs, attached by bind below.
// Assumes it observes the top's internal write strobe, stop flag and arming vector.
module i2c_staged_regs_chk #(
    parameter int NREG = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        pulses,
    input logic              wr_en,
    input logic [7:0]        wr_addr,
    input logic              stop,
    input logic              sda_oe,
    input logic [2:0]        pend,
    input logic [NREG*8-1:0] regs
);

    logic store;
    assign store = wr_en && (wr_addr == 8'hFF);

    AST_STORE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> (pend == 3'b111)); // R6

    AST_PEND_ONLY_BY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend)) != 3'b000) |-> $past(store)); // R6

    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (((pulses & pend) != 3'b000) && !store) |=> ((pend & $past(pulses)) == 3'b000)); // R7

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((pulses & pend) == 3'b000) |=> $stable(regs)); // R5

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !sda_oe); // R3

endmodule

bind i2c_staged_regs i2c_staged_regs_chk #(.NREG(NREG)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulses  (sync_vec),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .stop    (stop_det),
    .sda_oe  (sda_oe_o),
    .pend    (pend_vec),
    .regs    (regs_o)
);

// File: tb/sim_i2c_staged_regs.sv
// Bench: bus-level master tasks plus a behavioural model of staging, arming and commit.
module sim_i2c_staged_regs;

    localparam int NREG = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic vs_m = 1'b0;
    logic vs_s = 1'b0;
    logic os_p = 1'b0;
    logic sda_oe;
    logic [NREG*8-1:0] regs;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    i2c_staged_regs u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .vsync_main_i (vs_m),
        .vsync_sec_i  (vs_s),
        .out_start_i  (os_p),
        .regs_o       (regs)
    );

    int tests = 0;
    int fails = 0;
    int q = 20;
    bit done = 1'b0;
    int cyc_bad = 0;

    logic [7:0] mstage [NREG];
    logic [7:0] mact   [NREG];
    logic [2:0] mpend = 3'b000;

    function automatic int grp_b(input int i);
        return (i < 3) ? 0 : ((i < 5) ? 1 : 2);
    endfunction

    function automatic logic [NREG*8-1:0] mflat();
        logic [NREG*8-1:0] r;
        for (int i = 0; i < NREG; i++) r[8*i +: 8] = mact[i];
        return r;
    endfunction

    function automatic logic [7:0] mread(input logic [7:0] a);
        if (a < 8'(NREG)) return mact[a[2:0]];
        if (a >= 8'h80 && a <= 8'h82) return {7'b0, mpend[a - 8'h80]};
        return 8'h00;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Model commit at the same edge where the design samples the pulse.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mact[i] = 8'h00;
            mpend = 3'b000;
        end else begin
            for (int g = 0; g < 3; g++) begin
                if ({os_p, vs_s, vs_m}[g] && mpend[g]) begin
                    for (int i = 0; i < NREG; i++) if (grp_b(i) == g) mact[i] = mstage[i];
                    mpend[g] = 1'b0;
                end
            end
        end
    end

    // Every-cycle comparison of the active outputs (R5, R7).
    always @(negedge clk) begin
        if (rst_n && !done && (regs !== mflat())) begin
            if (cyc_bad == 0)
                $display("FAIL R7 per-cycle regs_o: actual %0h expected %0h", regs, mflat());
            cyc_bad++;
        end
    end

    task automatic hq();
        repeat (q) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
    endtask

    task automatic bstop();
        sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq();
    endtask

    task automatic tx_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
        end
        sda_m = 1'b1; hq(); scl_m = 1'b1; hq();
        ack = (sda_line == 1'b0);
        hq(); scl_m = 1'b0; hq();
    endtask

    task automatic rx_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; hq(); scl_m = 1'b1; hq();
            b[i] = sda_line;
            hq(); scl_m = 1'b0; hq();
        end
        sda_m = give_ack ? 1'b0 : 1'b1; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
        sda_m = 1'b1;
    endtask

    task automatic wr_txn(input logic [7:0] sub, input int n, input logic [7:0] d [4]);
        bit a;
        logic [7:0] p;
        bstart();
        tx_byte(8'hBC, a); chk(a, "R1 write address ACK", 64'(a), 1);
        tx_byte(sub, a);   chk(a, "R2 sub-address ACK", 64'(a), 1);
        p = sub;
        for (int k = 0; k < n; k++) begin
            tx_byte(d[k], a); chk(a, "R2 data byte ACK", 64'(a), 1);
            if (p < 8'(NREG)) mstage[p[2:0]] = d[k];
            else if (p == 8'hFF) mpend = 3'b111;
            p = p + 8'd1;
        end
        bstop();
    endtask

    task automatic rd_txn(input logic [7:0] sub, input int n, input string tag);
        bit a;
        logic [7:0] b;
        bstart();
        tx_byte(8'hBC, a); chk(a, "R1 write address ACK", 64'(a), 1);
        tx_byte(sub, a);   chk(a, "R2 sub-address ACK", 64'(a), 1);
        bstart();
        tx_byte(8'hBD, a); chk(a, "R1 read address ACK", 64'(a), 1);
        for (int k = 0; k < n; k++) begin
            rx_byte(k != n - 1, b);
            chk(b === mread(sub + 8'(k)), tag, 64'(b), 64'(mread(sub + 8'(k))));
        end
        chk(sda_oe == 1'b0, "R3 SDA released after NACK", 64'(sda_oe), 0);
        bstop();
    endtask

    task automatic pulse(input int g);
        @(negedge clk);
        if (g == 0) vs_m = 1'b1; else if (g == 1) vs_s = 1'b1; else os_p = 1'b1;
        @(negedge clk);
        vs_m = 1'b0; vs_s = 1'b0; os_p = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit a;
        for (int i = 0; i < NREG; i++) mstage[i] = 8'h00;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(regs == '0, "R13 reset regs_o", 64'(regs), 0);
        chk(sda_oe == 1'b0, "R13 reset SDA released", 64'(sda_oe), 0);

        // R1: foreign address is not acknowledged and following bytes are ignored
        bstart();
        tx_byte(8'hA0, a); chk(!a, "R1 foreign address NACK", 64'(a), 0);
        tx_byte(8'hFF, a); chk(!a, "R1 no ACK after foreign address", 64'(a), 0);
        bstop();
        rd_txn(8'h80, 3, "R1 status untouched by foreign transfer");

        // R2 R5: fill all staging bytes, outputs stay zero
        wr_txn(8'h00, 4, '{8'h11, 8'h22, 8'h33, 8'h44});
        wr_txn(8'h04, 4, '{8'h55, 8'h66, 8'h77, 8'h88});
        chk(regs == '0, "R5 staged writes not visible", 64'(regs), 0);
        pulse(0);
        chk(regs == '0, "R7 pulse without store ignored", 64'(regs), 0);
        rd_txn(8'h00, 2, "R10 read returns active not staged");

        // R6 R8: store arms all groups
        wr_txn(8'hFF, 1, '{8'h5A, 8'h00, 8'h00, 8'h00});
        rd_txn(8'h80, 3, "R6 R8 status after store");

        // R7 R11: output-start group commits registers 5..7 only
        pulse(2);
        chk(regs == 64'h8877_6600_0000_0000, "R11 output group commit", 64'(regs), 64'h8877_6600_0000_0000);
        rd_txn(8'h80, 3, "R7 status after output pulse");
        pulse(0);
        chk(regs == 64'h8877_6600_0033_2211, "R11 main group commit", 64'(regs), 64'h8877_6600_0033_2211);

        // R9: re-store while armed, later staging wins
        wr_txn(8'h03, 2, '{8'hA4, 8'hB5, 8'h00, 8'h00});
        wr_txn(8'hFF, 1, '{8'h01, 8'h00, 8'h00, 8'h00});
        wr_txn(8'h03, 1, '{8'hC6, 8'h00, 8'h00, 8'h00});
        pulse(1);
        chk(regs[39:24] == 16'hB5C6, "R9 newest staging committed", 64'(regs[39:24]), 64'hB5C6);
        rd_txn(8'h00, 8, "R10 R3 sequential active read-back");

        // R4: write pointer wrap through store to register 0
        wr_txn(8'hFE, 3, '{8'h99, 8'h00, 8'hD7, 8'h00});
        pulse(0);
        chk(regs[7:0] == 8'hD7, "R4 write wrap to register 0", 64'(regs[7:0]), 64'hD7);
        rd_txn(8'hFF, 2, "R4 read wrap 0xFF to 0x00");

        // R10 R8: unassigned and status writes are ignored
        wr_txn(8'h40, 1, '{8'hEE, 8'h00, 8'h00, 8'h00});
        rd_txn(8'h40, 1, "R10 unassigned reads zero");
        wr_txn(8'h81, 1, '{8'h00, 8'h00, 8'h00, 8'h00});
        rd_txn(8'h80, 3, "R8 status write ignored");

        // R12: fast-mode rate
        q = 78;
        wr_txn(8'h05, 1, '{8'h3C, 8'h00, 8'h00, 8'h00});
        pulse(2);
        chk(regs[47:40] == 8'h3C, "R12 fast-mode write committed", 64'(regs[47:40]), 64'h3C);
        rd_txn(8'h05, 1, "R12 fast-mode read");

        // R12: standard-mode rate
        q = 312;
        wr_txn(8'h06, 1, '{8'h5D, 8'h00, 8'h00, 8'h00});
        q = 20;
        wr_txn(8'hFF, 1, '{8'h00, 8'h00, 8'h00, 8'h00});
        pulse(2);
        chk(regs[55:48] == 8'h5D, "R12 standard-mode write committed", 64'(regs[55:48]), 64'h5D);

        repeat (5) @(negedge clk);
        chk(cyc_bad == 0, "R5 R7 every-cycle regs_o match", 64'(cyc_bad), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule